// File: doc/BRIEF.md
# Recalibrated ADC Drive Clock Generator

This block runs in a fast clock domain, the local crystal clock after frequency multiplication. It divides that fast clock by an even ratio N to produce the drive clock for a bank of sigma-delta converters. No phase-locked loop is used: an external slow calibration clock is sampled instead. Each of its rising edges restarts the divider, so the drive clock starts a fresh high phase at that edge. Frequency error of the local crystal therefore cannot build up for longer than one calibration period.

A new divide ratio is first written to a shadow register. It takes effect at the next calibration edge, so a change of sampling rate is resynchronised within one calibration period. A synchronisation command is held until the next calibration edge. It then goes out as a sync event one drive period long, aligned with the realigned drive clock.

The block also watches the converters' active-low data-ready line. It releases the converted data for upload a fixed 24 drive-clock periods after that line falls, so the upload point does not depend on small phase jitter between data-ready and any edge.

Top module: `adc_drive_clkgen`

## Requirements
- R1: While rst_n is low, adc_clk, sync_evt and data_release are 0. adc_clk first goes high on the third rising edge of clk_fast at which rst_n is high, with the default ratio N = 80.
- R2: With no calibration edge, adc_clk is high for N/2 fast cycles and then low for N/2 fast cycles, repeating.
- R3: When cal_in has been low and is then sampled high, adc_clk is high from the third rising edge at which cal_in is sampled high, whatever phase it was in. From that edge a full high phase of N/2 cycles follows. Holding cal_in high causes no further realignment.
- R4: A div_wr pulse with an even div_val of at least 4 stores the value in a shadow register. The current period stays unchanged until the next realignment, and the stored ratio applies from that realignment on.
- R5: A div_wr pulse with an odd div_val, or with div_val below 4, is ignored, and the shadow register keeps its earlier value.
- R6: A one-cycle sync_cmd pulse does not affect sync_evt at once. At the next realignment, sync_evt goes high in the same cycle as adc_clk and stays high for exactly N fast cycles.
- R7: Several sync_cmd pulses before one realignment give a single sync_evt pulse. A realignment with no command pending leaves sync_evt low.
- R8: After drdy_n_in falls, count the adc_clk rising edges in cycles from the third edge at which drdy_n_in is sampled low. data_release is high for exactly one cycle, the cycle after the 24th such rising edge. A rising drdy_n_in produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Multiplied local clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| cal_in | input | 1 | Asynchronous calibration clock; its rising edge realigns the divider |
| drdy_n_in | input | 1 | Asynchronous active-low converter data-ready |
| sync_cmd | input | 1 | One-cycle synchronisation command, synchronous to clk_fast |
| div_wr | input | 1 | Write strobe for the shadow divide ratio |
| div_val | input | 8 | Requested divide ratio N |
| adc_clk | output | 1 | Converter drive clock |
| sync_evt | output | 1 | Sync event to the converters, one drive period long |
| data_release | output | 1 | One-cycle pulse that releases converted data for upload |

## Verification
The assertions assume that sync_cmd and div_wr are synchronous one-cycle pulses in the clk_fast domain. They also assume that calibration rising edges are further apart than one drive period, so a sync event ends before the next edge. The asynchronous inputs must hold each level for at least two fast cycles so the synchroniser sees every edge. The stimulus changes cal_in and drdy_n_in only on falling clock edges and holds cal_in high for 30 cycles. It spaces calibration edges several drive periods apart, and it drives the strobes for exactly one cycle.

// File: rtl/adc_clkgen_pkg.sv
package adc_clkgen_pkg;
  localparam int DIV_W          = 8;
  localparam int DIV_DEFAULT    = 80;
  localparam int RELEASE_CYCLES = 24;
  localparam int SYNC_STAGES    = 2;
  localparam int NUM_ASYNC      = 2;

  typedef logic [DIV_W-1:0] div_t;

  // A ratio is usable when it splits into two equal phases of at least 2.
  function automatic logic div_ok(input div_t v);
    return (v[0] == 1'b0) && (v >= div_t'(4));
  endfunction
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES      = 2,
  parameter bit DETECT_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], async_in};
      last_q <= sh_q[STAGES-1];
    end
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign edge_pulse = sh_q[STAGES-1] & ~last_q;
    end else begin : g_fall
      assign edge_pulse = ~sh_q[STAGES-1] & last_q;
    end
  endgenerate
endmodule

// File: rtl/adc_div_core.sv
module adc_div_core
  import adc_clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cal_rise,
  input  logic wr_en,
  input  div_t wr_val,
  output logic adc_clk,
  output logic tick,
  output logic wrap,
  output div_t n_cur
);
  div_t cnt_q, cnt_d;
  div_t n_q, n_d;
  div_t shadow_q, shadow_d;
  logic clk_q, clk_d;
  div_t half;
  div_t last_cnt;
  div_t cnt_inc;

  assign half     = n_q >> 1;
  assign last_cnt = n_q - div_t'(1);
  assign cnt_inc  = cnt_q + div_t'(1);
  assign wrap     = ~cal_rise & (cnt_q == last_cnt);

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en && div_ok(wr_val)) shadow_d = wr_val;
  end

  always_comb begin
    n_d   = n_q;
    cnt_d = cnt_inc;
    clk_d = (cnt_inc < half);
    if (cal_rise) begin
      n_d   = shadow_q;
      cnt_d = '0;
      clk_d = 1'b1;
    end else if (cnt_q == last_cnt) begin
      cnt_d = '0;
      clk_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= div_t'(DIV_DEFAULT - 1);
      n_q      <= div_t'(DIV_DEFAULT);
      shadow_q <= div_t'(DIV_DEFAULT);
      clk_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      n_q      <= n_d;
      shadow_q <= shadow_d;
      clk_q    <= clk_d;
    end
  end

  assign adc_clk = clk_q;
  assign tick    = (cnt_q == '0);
  assign n_cur   = n_q;
endmodule

// File: rtl/adc_sync_event.sv
module adc_sync_event (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_rise,
  input  logic wrap,
  input  logic cmd,
  output logic evt
);
  logic pend_q, pend_d;
  logic evt_q, evt_d;

  always_comb begin
    pend_d = cmd | (pend_q & ~cal_rise);
    evt_d  = evt_q;
    if (cal_rise && pend_q) evt_d = 1'b1;
    else if (wrap)          evt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      evt_q  <= evt_d;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/adc_release_timer.sv
module adc_release_timer
  import adc_clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_fall,
  input  logic tick,
  output logic release_pulse
);
  localparam int CW = $clog2(RELEASE_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rel_q, rel_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    rel_d   = 1'b0;
    if (drdy_fall) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && tick) begin
      if (cnt_q == LAST) begin
        armed_d = 1'b0;
        rel_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      rel_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      rel_q   <= rel_d;
    end
  end

  assign release_pulse = rel_q;
endmodule

// File: rtl/adc_drive_clkgen.sv
module adc_drive_clkgen
  import adc_clkgen_pkg::*;
(
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             cal_in,
  input  logic             drdy_n_in,
  input  logic             sync_cmd,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  output logic             adc_clk,
  output logic             sync_evt,
  output logic             data_release
);
  localparam logic [NUM_ASYNC-1:0] EDGE_SEL = 2'b01; // bit0 cal rise, bit1 drdy fall

  logic [1:0]           rst_sh_q;
  logic                 rst_q;
  logic [NUM_ASYNC-1:0] async_vec;
  logic [NUM_ASYNC-1:0] edge_vec;
  logic                 cal_rise;
  logic                 drdy_fall;
  logic                 div_tick;
  logic                 div_wrap;
  div_t                 n_cur;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_q = rst_sh_q[1];

  assign async_vec = {drdy_n_in, cal_in};

  generate
    for (genvar i = 0; i < NUM_ASYNC; i++) begin : g_in
      adc_edge_sync #(
        .STAGES     (SYNC_STAGES),
        .DETECT_RISE(EDGE_SEL[i])
      ) u_edge (
        .clk       (clk_fast),
        .rst_n     (rst_q),
        .async_in  (async_vec[i]),
        .edge_pulse(edge_vec[i])
      );
    end
  endgenerate

  assign cal_rise  = edge_vec[0];
  assign drdy_fall = edge_vec[1];

  adc_div_core u_div (
    .clk     (clk_fast),
    .rst_n   (rst_q),
    .cal_rise(cal_rise),
    .wr_en   (div_wr),
    .wr_val  (div_val),
    .adc_clk (adc_clk),
    .tick    (div_tick),
    .wrap    (div_wrap),
    .n_cur   (n_cur)
  );

  adc_sync_event u_evt (
    .clk     (clk_fast),
    .rst_n   (rst_q),
    .cal_rise(cal_rise),
    .wrap    (div_wrap),
    .cmd     (sync_cmd),
    .evt     (sync_evt)
  );

  adc_release_timer u_rel (
    .clk          (clk_fast),
    .rst_n        (rst_q),
    .drdy_fall    (drdy_fall),
    .tick         (div_tick),
    .release_pulse(data_release)
  );
endmodule

// File: rtl/adc_clkgen_checker.sv
module adc_clkgen_checker
  import adc_clkgen_pkg::*;
(
  input logic clk,
  input logic rst_ok,
  input logic cal_rise,
  input logic wrap,
  input div_t n_cur,
  input logic adc_clk,
  input logic sync_evt,
  input logic data_release
);
  a_r3_realign_high: assert property (@(posedge clk) disable iff (!rst_ok)
    cal_rise |=> adc_clk);

  a_r2_rise_source: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(adc_clk) |-> ($past(wrap) || $past(cal_rise)));

  a_r4_ratio_at_cal: assert property (@(posedge clk) disable iff (!rst_ok)
    !$stable(n_cur) |-> $past(cal_rise));

  a_r5_ratio_legal: assert property (@(posedge clk) disable iff (!rst_ok)
    (n_cur[0] == 1'b0) && (n_cur >= div_t'(4)));

  a_r6_evt_start: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(sync_evt) |-> ($past(cal_rise) && adc_clk));

  a_r6_evt_end: assert property (@(posedge clk) disable iff (!rst_ok)
    $fell(sync_evt) |-> $past(wrap));

  a_r8_release_single: assert property (@(posedge clk) disable iff (!rst_ok)
    data_release |=> !data_release);
endmodule

bind adc_drive_clkgen adc_clkgen_checker u_chk (
  .clk         (clk_fast),
  .rst_ok      (rst_q),
  .cal_rise    (cal_rise),
  .wrap        (div_wrap),
  .n_cur       (n_cur),
  .adc_clk     (adc_clk),
  .sync_evt    (sync_evt),
  .data_release(data_release)
);

// File: tb/adc_drive_clkgen_bench.sv
`timescale 1ns/1ps
module adc_drive_clkgen_bench;
  logic       clk_fast = 1'b0;
  logic       rst_n = 1'b0;
  logic       cal_in = 1'b0;
  logic       drdy_n_in = 1'b1;
  logic       sync_cmd = 1'b0;
  logic       div_wr = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       adc_clk, sync_evt, data_release;

  int cyc = 0;
  int checks = 0;
  int failures = 0;

  always #10 clk_fast = ~clk_fast;
  always @(posedge clk_fast) cyc <= cyc + 1;

  adc_drive_clkgen u_adc_drive_clkgen (
    .clk_fast(clk_fast), .rst_n(rst_n), .cal_in(cal_in), .drdy_n_in(drdy_n_in),
    .sync_cmd(sync_cmd), .div_wr(div_wr), .div_val(div_val),
    .adc_clk(adc_clk), .sync_evt(sync_evt), .data_release(data_release)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Called at a falling edge where cyc == st; compares len cycles of waveform.
  task automatic expect_wave(input int st, input int n, input int len,
                             input int ev_lo, input int ev_hi, input string req);
    int bad = 0;
    int act = 0;
    int exp = 0;
    for (int i = 0; i < len; i++) begin
      int ph = (cyc - st) % n;
      bit e_clk = (ph < n / 2);
      bit e_evt = (cyc >= ev_lo) && (cyc < ev_hi);
      if ((adc_clk !== e_clk) || (sync_evt !== e_evt)) begin
        if (bad == 0) begin
          act = {adc_clk, sync_evt};
          exp = {e_clk, e_evt};
        end
        bad++;
      end
      @(negedge clk_fast);
    end
    check(bad == 0, {req, " waveform {adc_clk,sync_evt}"}, act, exp);
  endtask

  task automatic cal_pulse(output int st);
    cal_in = 1'b1;
    st = cyc + 3;
    fork
      begin
        repeat (30) @(negedge clk_fast);
        cal_in = 1'b0;
      end
    join_none
    repeat (3) @(negedge clk_fast);
  endtask

  task automatic write_div(input int v);
    div_val = 8'(v);
    div_wr = 1'b1;
    @(negedge clk_fast);
    div_wr = 1'b0;
  endtask

  task automatic pulse_cmd();
    sync_cmd = 1'b1;
    @(negedge clk_fast);
    sync_cmd = 1'b0;
  endtask

  task automatic t_reset();
    int st;
    repeat (5) @(negedge clk_fast);
    check({adc_clk, sync_evt, data_release} == 3'b000, "R1 outputs in reset",
          {adc_clk, sync_evt, data_release}, 0);
    rst_n = 1'b1;
    st = cyc + 3;
    repeat (3) @(negedge clk_fast);
    expect_wave(st, 80, 240, 0, 0, "R1/R2 default divide");
  endtask

  task automatic t_realign();
    int st;
    repeat (17) @(negedge clk_fast);
    cal_pulse(st);
    expect_wave(st, 80, 240, 0, 0, "R3 realign, held high, no event (R7)");
    repeat (61) @(negedge clk_fast);
    cal_pulse(st);
    expect_wave(st, 80, 200, 0, 0, "R3 realign mid phase");
  endtask

  task automatic t_ratio();
    int st;
    int st2;
    repeat (20) @(negedge clk_fast);
    cal_pulse(st);
    expect_wave(st, 80, 100, 0, 0, "R4 before write");
    write_div(40);
    expect_wave(st, 80, 200, 0, 0, "R4 old ratio kept until cal");
    cal_pulse(st2);
    expect_wave(st2, 40, 160, 0, 0, "R4 new ratio after cal");
  endtask

  task automatic t_bad_ratio();
    int st;
    write_div(7);
    write_div(2);
    write_div(0);
    repeat (13) @(negedge clk_fast);
    cal_pulse(st);
    expect_wave(st, 40, 160, 0, 0, "R5 illegal ratios ignored");
  endtask

  task automatic t_sync();
    int st;
    int seen = 0;
    repeat (9) @(negedge clk_fast);
    pulse_cmd();
    for (int i = 0; i < 10; i++) begin
      if (sync_evt !== 1'b0) seen++;
      @(negedge clk_fast);
    end
    pulse_cmd();
    for (int i = 0; i < 10; i++) begin
      if (sync_evt !== 1'b0) seen++;
      @(negedge clk_fast);
    end
    check(seen == 0, "R6 event deferred until cal", seen, 0);
    cal_pulse(st);
    expect_wave(st, 40, 160, st, st + 40, "R6/R7 merged single event");
    repeat (25) @(negedge clk_fast);
    cal_pulse(st);
    expect_wave(st, 40, 160, 0, 0, "R7 no event without command");
  endtask

  task automatic t_release();
    int k;
    int rises = 0;
    int c = -1;
    int spurious = 0;
    int hit = 0;
    bit prev;
    repeat (50) @(negedge clk_fast);
    drdy_n_in = 1'b0;
    k = cyc + 1;
    prev = adc_clk;
    for (int i = 0; i < 24 * 40 + 200; i++) begin
      @(negedge clk_fast);
      if (cyc >= k + 2 && adc_clk && !prev) begin
        rises++;
        if (rises == 24) c = cyc;
      end
      prev = adc_clk;
      if (c >= 0 && cyc == c + 1) hit = data_release;
      else if (data_release) spurious++;
      if (i == 100) drdy_n_in = 1'b1;
    end
    check(hit == 1, "R8 release after 24 drive periods", hit, 1);
    check(spurious == 0, "R8 no release at other cycles", spurious, 0);
    spurious = 0;
    for (int i = 0; i < 24 * 40 + 100; i++) begin
      @(negedge clk_fast);
      if (data_release) spurious++;
    end
    check(spurious == 0, "R8 rising data-ready ignored", spurious, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_fast);
    failures++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk_fast);
    t_reset();
    t_realign();
    t_ratio();
    t_bad_ratio();
    t_sync();
    t_release();
    summary();
    $finish;
  end
endmodule